// File: doc/BRIEF.md
# Sequential Unsigned Multiplier with Narrow-Operand Shortcut

This block multiplies two 32-bit unsigned operands and returns the 64-bit product as a high word and a low word. It works one add-and-shift step per clock. The multiplier goes into a shift register whose low bit picks the addend for each step. The partial product shifts right into the top of that register. A step forms its shifted-in bit from the true sign of the previous sum, so the multiplicand is treated as signed while it is stepped. When the multiplicand's top bit is set, a correction after the last step adds the original multiplier into the high word. This makes the unsigned product correct.

When every bit from 12 upward is clear in both operands, a short run of 12 steps plus one closing shift is enough. The result then sits split across the partial-product register and the top of the shift register, and one realignment cycle joins the two parts. Wider operands take 32 steps plus the closing shift. A flag shows whether the high word is zero, so a caller can tell whether the product overflowed 32 bits.

The caller pulses `start` with the operands. `busy` stays high while the block works. `done` pulses once when the product and the flag are updated. The outputs then hold until the next completion.

Top module: `seqmul_u32`

## Requirements
- R1: When `done` is high, {`prod_hi`,`prod_lo`} equals the unsigned 64-bit product of the `op_a` and `op_b` values sampled in the cycle the start was accepted.
- R2: The short path is taken when (`op_a` | `op_b`) has bits 31..12 all zero, and `done` rises 14 clock edges after the accepting edge. Otherwise `done` rises 34 edges after it.
- R3: `hi_zero` is 1 exactly when `prod_hi` is zero. After a short-path run, `prod_hi` is 0 and `hi_zero` is 1.
- R4: A start is accepted on a clock edge where `start`=1 and `busy`=0. `busy` is 1 from the next cycle until the cycle `done` goes high. `done` is high for exactly one cycle, and `busy` is 0 in that cycle.
- R5: A `start` pulse while `busy` is 1 is ignored. The running operation completes with its own operands and its own latency.
- R6: `prod_hi`, `prod_lo` and `hi_zero` change only in the cycle `done` is high. Otherwise they hold, whatever the operand inputs do.
- R7: After reset, `busy`=0, `done`=0, `prod_hi`=0, `prod_lo`=0 and `hi_zero`=1.
- R8: When the multiplicand `op_b` has bit 31 set, the long path still gives the exact unsigned product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiply with the present operands |
| op_a | input | 32 | Multiplier, loaded into the step shift register |
| op_b | input | 32 | Multiplicand, added on steps where the shift register's low bit is 1 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result outputs were just updated |
| prod_hi | output | 32 | Upper 32 bits of the product |
| prod_lo | output | 32 | Lower 32 bits of the product |
| hi_zero | output | 1 | 1 when `prod_hi` is zero (no overflow beyond 32 bits) |

## Verification
The bench targets the operands on either side of the path boundary: 0xFFF, where both paths apply, and 0x1000, which must force the long path. If the selection picks the wrong bits, the measured latency is wrong; a short run on a wide operand also loses the upper bits. Multiplicands with bit 31 set, including all-ones against all-ones, catch a missing or misplaced unsigned correction, which would leave the high word short by the multiplier. Short products that fill all 24 bits catch a wrong realignment shift, which would scramble or drop the low 12 bits. A start pulse in mid-run and operand changes after completion catch a block that recaptures while busy or lets its outputs drift.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
    localparam int unsigned WORD_W_DEF  = 32;
    localparam int unsigned NARROW_W_DEF = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } seqmul_state_e;
endpackage

// File: rtl/seqmul_pathsel.sv
// Chooses the narrow path when no operand bit at or above NARROW_W is set.
module seqmul_pathsel #(
    parameter int unsigned W        = 32,
    parameter int unsigned NARROW_W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         narrow
);
    logic [W-1:0] either;
    always_comb begin
        either = a | b;
        narrow = ((either >> NARROW_W) == '0);
    end
endmodule

// File: rtl/seqmul_step.sv
// One multiply step: conditional add of the addend to the shifted partial
// product, with the true sign of the previous sum shifted in at the top.
module seqmul_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] part_q,
    input  logic [W-1:0] shreg_q,
    input  logic [W-1:0] addend,
    input  logic         sgn_q,
    output logic [W-1:0] part_d,
    output logic [W-1:0] shreg_d,
    output logic         sgn_d
);
    logic [W-1:0] opnd;
    logic [W-1:0] addv;
    logic         ovf;
    always_comb begin
        opnd    = {sgn_q, part_q[W-1:1]};
        addv    = shreg_q[0] ? addend : '0;
        part_d  = opnd + addv;
        ovf     = (opnd[W-1] == addv[W-1]) && (part_d[W-1] != opnd[W-1]);
        sgn_d   = part_d[W-1] ^ ovf;
        shreg_d = {part_q[0], shreg_q[W-1:1]};
    end
endmodule

// File: rtl/seqmul_finish.sv
// Final cycle: unsigned correction for the wide path, realignment for the
// narrow path, and the high-word-zero flag.
module seqmul_finish #(
    parameter int unsigned W        = 32,
    parameter int unsigned NARROW_W = 12
) (
    input  logic         narrow,
    input  logic [W-1:0] part_q,
    input  logic [W-1:0] shreg_q,
    input  logic [W-1:0] mcand_q,
    input  logic [W-1:0] mplier_q,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic         hz
);
    localparam int unsigned LO_SHIFT = W - NARROW_W;
    always_comb begin
        if (narrow) begin
            hi = '0;
            lo = (part_q << NARROW_W) | (shreg_q >> LO_SHIFT);
        end else begin
            hi = part_q + (mcand_q[W-1] ? mplier_q : '0);
            lo = shreg_q;
        end
        hz = (hi == '0);
    end
endmodule

// File: rtl/seqmul_u32.sv
module seqmul_u32
    import seqmul_pkg::*;
#(
    parameter int unsigned W        = WORD_W_DEF,
    parameter int unsigned NARROW_W = NARROW_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         hi_zero
);
    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        seqmul_state_e st;
        logic [W-1:0]  part;
        logic [W-1:0]  shreg;
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic          sgn;
        logic          narrow;
        logic [CW-1:0] left;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic          hz;
        logic          done;
    } seqmul_regs_t;

    seqmul_regs_t r_q, r_d;

    logic          narrow_sel;
    logic [W-1:0]  step_addend;
    logic [W-1:0]  step_part_d;
    logic [W-1:0]  step_shreg_d;
    logic          step_sgn_d;
    logic [W-1:0]  fin_hi;
    logic [W-1:0]  fin_lo;
    logic          fin_hz;

    seqmul_pathsel #(.W(W), .NARROW_W(NARROW_W)) u_sel (
        .a      (op_a),
        .b      (op_b),
        .narrow (narrow_sel)
    );

    assign step_addend = (r_q.left != '0) ? r_q.mcand : '0;

    seqmul_step #(.W(W)) u_step (
        .part_q  (r_q.part),
        .shreg_q (r_q.shreg),
        .addend  (step_addend),
        .sgn_q   (r_q.sgn),
        .part_d  (step_part_d),
        .shreg_d (step_shreg_d),
        .sgn_d   (step_sgn_d)
    );

    seqmul_finish #(.W(W), .NARROW_W(NARROW_W)) u_fin (
        .narrow   (r_q.narrow),
        .part_q   (r_q.part),
        .shreg_q  (r_q.shreg),
        .mcand_q  (r_q.mcand),
        .mplier_q (r_q.mplier),
        .hi       (fin_hi),
        .lo       (fin_lo),
        .hz       (fin_hz)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_RUN;
                    r_d.part   = '0;
                    r_d.sgn    = 1'b0;
                    r_d.shreg  = op_a;
                    r_d.mplier = op_a;
                    r_d.mcand  = op_b;
                    r_d.narrow = narrow_sel;
                    r_d.left   = narrow_sel ? CW'(NARROW_W) : CW'(W);
                end
            end
            ST_RUN: begin
                r_d.part  = step_part_d;
                r_d.shreg = step_shreg_d;
                r_d.sgn   = step_sgn_d;
                if (r_q.left != '0) begin
                    r_d.left = r_q.left - CW'(1);
                end else begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.hi   = fin_hi;
                r_d.lo   = fin_lo;
                r_d.hz   = fin_hz;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.hz     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign prod_hi = r_q.hi;
    assign prod_lo = r_q.lo;
    assign hi_zero = r_q.hz;
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
    parameter int unsigned W        = 32,
    parameter int unsigned NARROW_W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo,
    input logic         hi_zero
);
    localparam int unsigned LW       = $clog2(W + 3) + 1;
    localparam int unsigned LAT_NAR  = NARROW_W + 2;
    localparam int unsigned LAT_WIDE = W + 2;

    logic [LW-1:0] lat_q;
    logic          nar_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            nar_q <= 1'b0;
        end else if (start && !busy) begin
            lat_q <= '0;
            nar_q <= (((op_a | op_b) >> NARROW_W) == '0);
        end else if (busy) begin
            lat_q <= lat_q + LW'(1);
        end
    end

    // R2: completion edge count depends on the chosen path
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == (nar_q ? LW'(LAT_NAR) : LW'(LAT_WIDE))));

    // R3: flag agrees with the high word
    p_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_zero == (prod_hi == '0));

    // R3: narrow path never reports overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nar_q) |-> (hi_zero && prod_hi == '0));

    // R4: accepted start raises busy
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: done is a single-cycle pulse with busy low
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R6: results hold outside the done cycle
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(hi_zero)));
endmodule

bind seqmul_u32 seqmul_chk #(.W(W), .NARROW_W(NARROW_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo),
    .hi_zero (hi_zero)
);

// File: tb/seqmul_u32_tb.sv
module seqmul_u32_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        busy, done, hi_zero;
    logic [31:0] prod_hi, prod_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seqmul_u32 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo),
        .hi_zero(hi_zero)
    );

    function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
        return {32'b0, a} * {32'b0, b};
    endfunction

    function automatic int ref_lat(input logic [31:0] a, input logic [31:0] b);
        return (((a | b) >> 12) == 0) ? 14 : 34;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one operation; intrude=1 pulses start with other operands mid-run (R5)
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input bit intrude, input string req);
        int cyc;
        logic [63:0] exp;
        exp = ref_prod(a, b);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 3) begin
                op_a  = ~a;
                op_b  = ~b ^ 32'h5;
                start = 1'b1;
            end else if (intrude && cyc == 4) begin
                start = 1'b0;
            end
        end
        check64({req, " R1 product"}, {prod_hi, prod_lo}, exp);
        check64("R3 hi_zero flag", {63'b0, hi_zero}, {63'b0, (exp[63:32] == 0)});
        check64("R2 latency", 64'(cyc), 64'(ref_lat(a, b)));
        check64("R4 busy low at done", {63'b0, busy}, 64'b0);
        @(negedge clk);
        check64("R4 done single pulse", {63'b0, done}, 64'b0);
    endtask

    initial begin
        logic [31:0] ra, rb;
        logic [63:0] held;
        bit hz_held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R7: reset state
        check64("R7 reset outputs", {prod_hi, prod_lo}, 64'b0);
        check64("R7 reset flags", {61'b0, busy, done, hi_zero}, 64'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R7 after release", {61'b0, busy, done, hi_zero}, 64'b001);

        // R2 boundary and short path
        run_op(32'h0, 32'h0, 0, "R2 zero");
        run_op(32'hFFF, 32'hFFF, 0, "R2 narrow max");
        run_op(32'h1000, 32'h1, 0, "R2 wide boundary");
        run_op(32'hFFF, 32'h1000, 0, "R2 mixed boundary");
        run_op(32'h1, 32'h3, 0, "R3 narrow small");
        // R8: multiplicand MSB set
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, "R8 all ones");
        run_op(32'h1, 32'h80000000, 0, "R8 msb only");
        run_op(32'h80000000, 32'hFFFFFFFF, 0, "R8 msb both");
        run_op(32'hFFFFFFFF, 32'h0, 0, "R3 wide zero product");
        run_op(32'h12345678, 32'h9ABCDEF0, 0, "R8 mixed");
        // R5: start while busy ignored (wide and narrow)
        run_op(32'hDEADBEEF, 32'hCAFEF00D, 1, "R5 wide intrude");
        run_op(32'h0ABC, 32'h0123, 1, "R5 narrow intrude");

        // R6: outputs hold while operands move without start
        held    = {prod_hi, prod_lo};
        hz_held = hi_zero;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            op_a = $urandom;
            op_b = $urandom;
        end
        check64("R6 outputs hold", {prod_hi, prod_lo}, held);
        check64("R6 flag hold", {63'b0, hi_zero}, {63'b0, hz_held});

        // Random stimulus
        for (int i = 0; i < 200; i++) begin
            ra = $urandom;
            rb = $urandom;
            if (i % 5 == 0) rb[31] = 1'b1;
            run_op(ra, rb, 0, "R1 random wide");
        end
        for (int i = 0; i < 100; i++) begin
            ra = $urandom & 32'hFFF;
            rb = $urandom & 32'hFFF;
            run_op(ra, rb, 0, "R1 random narrow");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule